// File: doc/BRIEF.md
# Five-Pass HAVAL Compression Engine

This block computes the five-pass HAVAL compression function over one 1024-bit message block and a 256-bit chaining value. The chaining value lives in an internal register. A one-cycle `iv_load` pulse sets that register to the fixed initial vector. Each accepted `start` captures `block_in`, runs 160 rounds at one round per clock, and adds the original chaining words back into the result. The result then becomes the new chaining value, so blocks issued back to back chain with no extra action.

The 160 rounds form five passes of 32 rounds each. Every pass has its own seven-input bitwise function, a fixed reordering of the function's inputs, an order in which it reads the message words, and a table of additive constants. The first pass reads the words in natural order and adds zero.

Padding, length encoding and output truncation belong to the surrounding logic. The engine always returns all eight words.

Top module: `haval5_core`

## Requirements
- R1: With `busy` low, an `iv_load` pulse makes `state_out` equal to the initial vector from the next cycle. Word i sits at bits [32i+31:32i]: 0x243F6A88, 0x85A308D3, 0x13198A2E, 0x03707344, 0xA4093822, 0x299F31D0, 0x082EFA98, 0xEC4E6C89 for i = 0..7. An `iv_load` pulse while `busy` is high has no effect.
- R2: `start` is accepted when `busy` is low and `iv_load` is low. `busy` rises in the next cycle and stays high for exactly 160 cycles. A `start` that arrives together with `iv_load` is not accepted.
- R3: `done` is high for exactly one cycle, namely the first cycle in which `busy` is low again. It is never high at any other time.
- R4: A `start` raised while `busy` is high is ignored. It neither restarts nor lengthens the run, and the result uses the block captured when the run began.
- R5: When `done` is high, `state_out` holds the compression result. Each round rewrites the oldest working word with ror(t,7) + ror(old,11) + message word + constant, modulo 2^32. After round 160, every working word is added to the chaining word it started from.
- R6: `state_out` does not change while `busy` is high.
- R7: A second block processed without an `iv_load` in between starts from the previous result.
- R8: After a synchronous reset, `busy` and `done` are low and `state_out` holds the initial vector.
- R9: Message word k is taken from `block_in` bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iv_load | input | 1 | Load the initial vector into the chaining register |
| start | input | 1 | Begin compressing `block_in` |
| block_in | input | 1024 | Message block, word k at bits [32k+31:32k] |
| state_out | output | 256 | Chaining value, word i at bits [32i+31:32i] |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when a new result is present |

## Verification
The bench drives `start` again in the middle of a run while changing `block_in`. A design that restarted, or recaptured the block, would finish late or return the digest of the wrong block. It also pulses `iv_load` during a run and together with an idle `start`; an engine that honoured either would lose the chaining value or start a spurious run. Blocks are chained without reloading, so a design that fed forward from the initial vector instead of the stored chain would give a wrong second digest. A sparse block with one nonzero word, and a block whose word pattern singles out each position, would expose a reversed word order or a wrong per-pass message selection.

// File: rtl/haval5_pkg.sv
package haval5_pkg;

    localparam int WORD_W         = 32;
    localparam int STATE_WORDS    = 8;
    localparam int MSG_WORDS      = 32;
    localparam int PASSES         = 5;
    localparam int STEPS_PER_PASS = 32;
    localparam int TOTAL_STEPS    = PASSES * STEPS_PER_PASS;
    localparam int STEP_W         = $clog2(TOTAL_STEPS);
    localparam int IDX_W          = $clog2(STEPS_PER_PASS);
    localparam int SEL_W          = $clog2(MSG_WORDS);
    localparam int PASS_W         = 3;
    localparam int ROT_T          = 7;
    localparam int ROT_OLD        = 11;

    typedef logic [WORD_W-1:0]                   word_t;
    typedef logic [STATE_WORDS-1:0][WORD_W-1:0] hstate_t;
    typedef logic [MSG_WORDS-1:0][WORD_W-1:0]   hblock_t;

    typedef enum logic [PASS_W-1:0] {
        PASS_A = 3'd0,
        PASS_B = 3'd1,
        PASS_C = 3'd2,
        PASS_D = 3'd3,
        PASS_E = 3'd4
    } pass_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        word_t            k;
    } step_param_t;

    // word 7 first so that index i of the packed array is word i
    localparam hstate_t IV = {
        32'hEC4E6C89, 32'h082EFA98, 32'h299F31D0, 32'hA4093822,
        32'h03707344, 32'h13198A2E, 32'h85A308D3, 32'h243F6A88
    };

    function automatic word_t ror_by(word_t v, int unsigned amt);
        return (v >> amt) | (v << (WORD_W - amt));
    endfunction

    function automatic word_t bf1(word_t a6, word_t a5, word_t a4, word_t a3,
                                  word_t a2, word_t a1, word_t a0);
        return a0 ^ ((a0 ^ a4) & a1) ^ (a2 & a5) ^ (a3 & a6);
    endfunction

    function automatic word_t bf2(word_t a6, word_t a5, word_t a4, word_t a3,
                                  word_t a2, word_t a1, word_t a0);
        return (a2 & ((~a3 & a1) ^ (a4 & a5) ^ a6 ^ a0))
             ^ (a4 & (a1 ^ a5)) ^ (a3 & a5) ^ a0;
    endfunction

    function automatic word_t bf3(word_t a6, word_t a5, word_t a4, word_t a3,
                                  word_t a2, word_t a1, word_t a0);
        return (a3 & ((a1 & a2) ^ a6 ^ a0)) ^ (a1 & a4) ^ (a2 & a5) ^ a0;
    endfunction

    function automatic word_t bf4(word_t a6, word_t a5, word_t a4, word_t a3,
                                  word_t a2, word_t a1, word_t a0);
        return (a3 & ((a1 & a2) ^ (a4 | a6) ^ a5))
             ^ (a4 & ((~a2 & a5) ^ a1 ^ a6 ^ a0))
             ^ (a2 & a6) ^ a0;
    endfunction

    function automatic word_t bf5(word_t a6, word_t a5, word_t a4, word_t a3,
                                  word_t a2, word_t a1, word_t a0);
        return (a0 & ~((a1 & a2 & a3) ^ a5)) ^ (a1 & a4) ^ (a2 & a5) ^ (a3 & a6);
    endfunction

    // pass function with its input reordering; w[i] is operand xi
    function automatic word_t pass_mix(pass_e p, hstate_t w);
        word_t r;
        case (p)
            PASS_A:  r = bf1(w[3], w[4], w[1], w[0], w[5], w[2], w[6]);
            PASS_B:  r = bf2(w[6], w[2], w[1], w[0], w[3], w[4], w[5]);
            PASS_C:  r = bf3(w[2], w[6], w[0], w[4], w[3], w[1], w[5]);
            PASS_D:  r = bf4(w[1], w[5], w[3], w[2], w[0], w[4], w[6]);
            default: r = bf5(w[2], w[5], w[0], w[6], w[4], w[3], w[1]);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/haval5_rom.sv
module haval5_rom
    import haval5_pkg::*;
(
    input  pass_e             pass,
    input  logic [IDX_W-1:0]  idx,
    output step_param_t       prm
);

    localparam int TBLS = PASSES - 1;

    localparam logic [SEL_W-1:0] SEL_TBL [TBLS][STEPS_PER_PASS] = '{
        '{5'd5,  5'd14, 5'd26, 5'd18, 5'd11, 5'd28, 5'd7,  5'd16,
          5'd0,  5'd23, 5'd20, 5'd22, 5'd1,  5'd10, 5'd4,  5'd8,
          5'd30, 5'd3,  5'd21, 5'd9,  5'd17, 5'd24, 5'd29, 5'd6,
          5'd19, 5'd12, 5'd15, 5'd13, 5'd2,  5'd25, 5'd31, 5'd27},
        '{5'd19, 5'd9,  5'd4,  5'd20, 5'd28, 5'd17, 5'd8,  5'd22,
          5'd29, 5'd14, 5'd25, 5'd12, 5'd24, 5'd30, 5'd16, 5'd26,
          5'd31, 5'd15, 5'd7,  5'd3,  5'd1,  5'd0,  5'd18, 5'd27,
          5'd13, 5'd6,  5'd21, 5'd10, 5'd23, 5'd11, 5'd5,  5'd2},
        '{5'd24, 5'd4,  5'd0,  5'd14, 5'd2,  5'd7,  5'd28, 5'd23,
          5'd26, 5'd6,  5'd30, 5'd20, 5'd18, 5'd25, 5'd19, 5'd3,
          5'd22, 5'd11, 5'd31, 5'd21, 5'd8,  5'd27, 5'd12, 5'd9,
          5'd1,  5'd29, 5'd5,  5'd15, 5'd17, 5'd10, 5'd16, 5'd13},
        '{5'd27, 5'd3,  5'd21, 5'd26, 5'd17, 5'd11, 5'd20, 5'd29,
          5'd19, 5'd0,  5'd12, 5'd7,  5'd13, 5'd8,  5'd31, 5'd10,
          5'd5,  5'd9,  5'd14, 5'd30, 5'd18, 5'd6,  5'd28, 5'd24,
          5'd2,  5'd23, 5'd16, 5'd22, 5'd4,  5'd1,  5'd25, 5'd15}
    };

    localparam word_t K_TBL [TBLS][STEPS_PER_PASS] = '{
        '{32'h452821E6, 32'h38D01377, 32'hBE5466CF, 32'h34E90C6C,
          32'hC0AC29B7, 32'hC97C50DD, 32'h3F84D5B5, 32'hB5470917,
          32'h9216D5D9, 32'h8979FB1B, 32'hD1310BA6, 32'h98DFB5AC,
          32'h2FFD72DB, 32'hD01ADFB7, 32'hB8E1AFED, 32'h6A267E96,
          32'hBA7C9045, 32'hF12C7F99, 32'h24A19947, 32'hB3916CF7,
          32'h0801F2E2, 32'h858EFC16, 32'h636920D8, 32'h71574E69,
          32'hA458FEA3, 32'hF4933D7E, 32'h0D95748F, 32'h728EB658,
          32'h718BCD58, 32'h82154AEE, 32'h7B54A41D, 32'hC25A59B5},
        '{32'h9C30D539, 32'h2AF26013, 32'hC5D1B023, 32'h286085F0,
          32'hCA417918, 32'hB8DB38EF, 32'h8E79DCB0, 32'h603A180E,
          32'h6C9E0E8B, 32'hB01E8A3E, 32'hD71577C1, 32'hBD314B27,
          32'h78AF2FDA, 32'h55605C60, 32'hE65525F3, 32'hAA55AB94,
          32'h57489862, 32'h63E81440, 32'h55CA396A, 32'h2AAB10B6,
          32'hB4CC5C34, 32'h1141E8CE, 32'hA15486AF, 32'h7C72E993,
          32'hB3EE1411, 32'h636FBC2A, 32'h2BA9C55D, 32'h741831F6,
          32'hCE5C3E16, 32'h9B87931E, 32'hAFD6BA33, 32'h6C24CF5C},
        '{32'h7A325381, 32'h28958677, 32'h3B8F4898, 32'h6B4BB9AF,
          32'hC4BFE81B, 32'h66282193, 32'h61D809CC, 32'hFB21A991,
          32'h487CAC60, 32'h5DEC8032, 32'hEF845D5D, 32'hE98575B1,
          32'hDC262302, 32'hEB651B88, 32'h23893E81, 32'hD396ACC5,
          32'h0F6D6FF3, 32'h83F44239, 32'h2E0B4482, 32'hA4842004,
          32'h69C8F04A, 32'h9E1F9B5E, 32'h21C66842, 32'hF6E96C9A,
          32'h670C9C61, 32'hABD388F0, 32'h6A51A0D2, 32'hD8542F68,
          32'h960FA728, 32'hAB5133A3, 32'h6EEF0B6C, 32'h137A3BE4},
        '{32'hBA3BF050, 32'h7EFB2A98, 32'hA1F1651D, 32'h39AF0176,
          32'h66CA593E, 32'h82430E88, 32'h8CEE8619, 32'h456F9FB4,
          32'h7D84A5C3, 32'h3B8B5EBE, 32'hE06F75D8, 32'h85C12073,
          32'h401A449F, 32'h56C16AA6, 32'h4ED3AA62, 32'h363F7706,
          32'h1BFEDF72, 32'h429B023D, 32'h37D0D724, 32'hD00A1248,
          32'hDB0FEAD3, 32'h49F1C09B, 32'h075372C9, 32'h80991B7B,
          32'h25D479D8, 32'hF6E8DEF7, 32'hE3FE501A, 32'hB6794C3B,
          32'h976CE0BD, 32'h04C006BA, 32'hC1A94FB6, 32'h409F60C4}
    };

    logic [1:0] tsel;
    assign tsel = 2'(3'(pass) - 3'd1);

    always_comb begin
        if (pass == PASS_A) begin
            prm.sel = SEL_W'(idx);
            prm.k   = '0;
        end else begin
            prm.sel = SEL_TBL[tsel][idx];
            prm.k   = K_TBL[tsel][idx];
        end
    end

endmodule

// File: rtl/haval5_step.sv
module haval5_step
    import haval5_pkg::*;
(
    input  hstate_t work,
    input  pass_e   pass,
    input  word_t   msg_word,
    input  word_t   k,
    output hstate_t next_work
);

    word_t t;
    word_t fresh;

    assign t     = pass_mix(pass, work);
    assign fresh = ror_by(t, ROT_T) + ror_by(work[STATE_WORDS-1], ROT_OLD) + msg_word + k;

    // operand slots slide up by one; the new word enters at slot 0
    assign next_work = {work[STATE_WORDS-2:0], fresh};

endmodule

// File: rtl/haval5_seq.sv
module haval5_seq
    import haval5_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             iv_load,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic             last,
    output pass_e            pass,
    output logic [IDX_W-1:0] idx
);

    logic [STEP_W-1:0] cnt;

    assign accept = start && !busy && !iv_load;
    assign last   = busy && (cnt == STEP_W'(TOTAL_STEPS - 1));
    assign pass   = pass_e'(PASS_W'(cnt >> IDX_W));
    assign idx    = cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= last;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/haval5_core.sv
module haval5_core
    import haval5_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          iv_load,
    input  logic                          start,
    input  logic [MSG_WORDS*WORD_W-1:0]   block_in,
    output logic [STATE_WORDS*WORD_W-1:0] state_out,
    output logic                          busy,
    output logic                          done
);

    hstate_t          chain;
    hstate_t          work;
    hstate_t          next_work;
    hstate_t          fed;
    hblock_t          msg;
    logic             accept;
    logic             last;
    pass_e            pass;
    logic [IDX_W-1:0] idx;
    step_param_t      prm;
    word_t            msg_word;

    haval5_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .iv_load (iv_load),
        .busy    (busy),
        .done    (done),
        .accept  (accept),
        .last    (last),
        .pass    (pass),
        .idx     (idx)
    );

    haval5_rom u_rom (
        .pass (pass),
        .idx  (idx),
        .prm  (prm)
    );

    assign msg_word = msg[prm.sel];

    haval5_step u_step (
        .work      (work),
        .pass      (pass),
        .msg_word  (msg_word),
        .k         (prm.k),
        .next_work (next_work)
    );

    // feed-forward: after a multiple of eight rounds the slots line up again
    for (genvar gi = 0; gi < STATE_WORDS; gi++) begin : g_feed
        assign fed[gi] = chain[gi] + next_work[gi];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= IV;
            work  <= '0;
            msg   <= '0;
        end else begin
            if (!busy && iv_load) begin
                chain <= IV;
            end
            if (accept) begin
                work <= chain;
                msg  <= block_in;
            end else if (busy) begin
                work <= next_work;
            end
            if (last) begin
                chain <= fed;
            end
        end
    end

    assign state_out = chain;

endmodule

// File: rtl/haval5_core_chk.sv
module haval5_core_chk
    import haval5_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          iv_load,
    input logic                          start,
    input logic [STATE_WORDS*WORD_W-1:0] state_out,
    input logic                          busy,
    input logic                          done
);

    logic [STEP_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R1
    iv_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_load && !busy) |=> (state_out == IV));

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !iv_load) |=> busy);

    // R2
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == (STEP_W+1)'(TOTAL_STEPS)));

    // R4
    run_cap_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < (STEP_W+1)'(TOTAL_STEPS)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(state_out));

endmodule

bind haval5_core haval5_core_chk u_chk (.*);

// File: tb/haval5_core_test.sv
module haval5_core_test;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iv_load = 1'b0;
    logic          start = 1'b0;
    logic [1023:0] block_in = '0;
    logic [255:0]  state_out;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    haval5_core uut (
        .clk       (clk),
        .rst       (rst),
        .iv_load   (iv_load),
        .start     (start),
        .block_in  (block_in),
        .state_out (state_out),
        .busy      (busy),
        .done      (done)
    );

    localparam logic [255:0] INIT_VEC = {
        32'hEC4E6C89, 32'h082EFA98, 32'h299F31D0, 32'hA4093822,
        32'h03707344, 32'h13198A2E, 32'h85A308D3, 32'h243F6A88
    };

    // argument sources listed for a6 down to a0
    localparam int ARGSRC [5][7] = '{
        '{3, 4, 1, 0, 5, 2, 6},
        '{6, 2, 1, 0, 3, 4, 5},
        '{2, 6, 0, 4, 3, 1, 5},
        '{1, 5, 3, 2, 0, 4, 6},
        '{2, 5, 0, 6, 4, 3, 1}
    };

    localparam int ORD [4][32] = '{
        '{5,14,26,18,11,28,7,16, 0,23,20,22,1,10,4,8, 30,3,21,9,17,24,29,6, 19,12,15,13,2,25,31,27},
        '{19,9,4,20,28,17,8,22, 29,14,25,12,24,30,16,26, 31,15,7,3,1,0,18,27, 13,6,21,10,23,11,5,2},
        '{24,4,0,14,2,7,28,23, 26,6,30,20,18,25,19,3, 22,11,31,21,8,27,12,9, 1,29,5,15,17,10,16,13},
        '{27,3,21,26,17,11,20,29, 19,0,12,7,13,8,31,10, 5,9,14,30,18,6,28,24, 2,23,16,22,4,1,25,15}
    };

    localparam logic [31:0] ADD [4][32] = '{
        '{32'h452821E6, 32'h38D01377, 32'hBE5466CF, 32'h34E90C6C, 32'hC0AC29B7, 32'hC97C50DD, 32'h3F84D5B5, 32'hB5470917,
          32'h9216D5D9, 32'h8979FB1B, 32'hD1310BA6, 32'h98DFB5AC, 32'h2FFD72DB, 32'hD01ADFB7, 32'hB8E1AFED, 32'h6A267E96,
          32'hBA7C9045, 32'hF12C7F99, 32'h24A19947, 32'hB3916CF7, 32'h0801F2E2, 32'h858EFC16, 32'h636920D8, 32'h71574E69,
          32'hA458FEA3, 32'hF4933D7E, 32'h0D95748F, 32'h728EB658, 32'h718BCD58, 32'h82154AEE, 32'h7B54A41D, 32'hC25A59B5},
        '{32'h9C30D539, 32'h2AF26013, 32'hC5D1B023, 32'h286085F0, 32'hCA417918, 32'hB8DB38EF, 32'h8E79DCB0, 32'h603A180E,
          32'h6C9E0E8B, 32'hB01E8A3E, 32'hD71577C1, 32'hBD314B27, 32'h78AF2FDA, 32'h55605C60, 32'hE65525F3, 32'hAA55AB94,
          32'h57489862, 32'h63E81440, 32'h55CA396A, 32'h2AAB10B6, 32'hB4CC5C34, 32'h1141E8CE, 32'hA15486AF, 32'h7C72E993,
          32'hB3EE1411, 32'h636FBC2A, 32'h2BA9C55D, 32'h741831F6, 32'hCE5C3E16, 32'h9B87931E, 32'hAFD6BA33, 32'h6C24CF5C},
        '{32'h7A325381, 32'h28958677, 32'h3B8F4898, 32'h6B4BB9AF, 32'hC4BFE81B, 32'h66282193, 32'h61D809CC, 32'hFB21A991,
          32'h487CAC60, 32'h5DEC8032, 32'hEF845D5D, 32'hE98575B1, 32'hDC262302, 32'hEB651B88, 32'h23893E81, 32'hD396ACC5,
          32'h0F6D6FF3, 32'h83F44239, 32'h2E0B4482, 32'hA4842004, 32'h69C8F04A, 32'h9E1F9B5E, 32'h21C66842, 32'hF6E96C9A,
          32'h670C9C61, 32'hABD388F0, 32'h6A51A0D2, 32'hD8542F68, 32'h960FA728, 32'hAB5133A3, 32'h6EEF0B6C, 32'h137A3BE4},
        '{32'hBA3BF050, 32'h7EFB2A98, 32'hA1F1651D, 32'h39AF0176, 32'h66CA593E, 32'h82430E88, 32'h8CEE8619, 32'h456F9FB4,
          32'h7D84A5C3, 32'h3B8B5EBE, 32'hE06F75D8, 32'h85C12073, 32'h401A449F, 32'h56C16AA6, 32'h4ED3AA62, 32'h363F7706,
          32'h1BFEDF72, 32'h429B023D, 32'h37D0D724, 32'hD00A1248, 32'hDB0FEAD3, 32'h49F1C09B, 32'h075372C9, 32'h80991B7B,
          32'h25D479D8, 32'hF6E8DEF7, 32'hE3FE501A, 32'hB6794C3B, 32'h976CE0BD, 32'h04C006BA, 32'hC1A94FB6, 32'h409F60C4}
    };

    function automatic logic [31:0] rr(logic [31:0] v, int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    function automatic logic [31:0] boolf(int p, logic [31:0] x [8]);
        logic [31:0] a [7];
        logic [31:0] r;
        for (int n = 0; n < 7; n++) a[6 - n] = x[ARGSRC[p][n]];
        case (p)
            0: r = a[0] ^ ((a[0] ^ a[4]) & a[1]) ^ (a[2] & a[5]) ^ (a[3] & a[6]);
            1: r = (a[2] & ((~a[3] & a[1]) ^ (a[4] & a[5]) ^ a[6] ^ a[0]))
                   ^ (a[4] & (a[1] ^ a[5])) ^ (a[3] & a[5]) ^ a[0];
            2: r = (a[3] & ((a[1] & a[2]) ^ a[6] ^ a[0])) ^ (a[1] & a[4]) ^ (a[2] & a[5]) ^ a[0];
            3: r = (a[3] & ((a[1] & a[2]) ^ (a[4] | a[6]) ^ a[5]))
                   ^ (a[4] & ((~a[2] & a[5]) ^ a[1] ^ a[6] ^ a[0])) ^ (a[2] & a[6]) ^ a[0];
            default: r = (a[0] & ~((a[1] & a[2] & a[3]) ^ a[5])) ^ (a[1] & a[4]) ^ (a[2] & a[5]) ^ (a[3] & a[6]);
        endcase
        return r;
    endfunction

    // state kept in place; the written word and operand positions move each round
    function automatic logic [255:0] ref_compress(logic [255:0] c, logic [1023:0] b);
        logic [31:0] s [8];
        logic [31:0] x [8];
        logic [31:0] t;
        logic [255:0] r;
        int sel;
        logic [31:0] kc;
        for (int i = 0; i < 8; i++) s[i] = c[32*i +: 32];
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < 32; i++) begin
                int rot;
                rot = (p * 32 + i) % 8;
                for (int q = 0; q < 8; q++) x[q] = s[(q - rot + 8) % 8];
                t = boolf(p, x);
                sel = (p == 0) ? i : ORD[p-1][i];
                kc  = (p == 0) ? 32'h0 : ADD[p-1][i];
                s[7 - rot] = rr(t, 7) + rr(s[7 - rot], 11) + b[32*sel +: 32] + kc;
            end
        end
        for (int i = 0; i < 8; i++) r[32*i +: 32] = s[i] + c[32*i +: 32];
        return r;
    endfunction

    function automatic logic [1023:0] mk_block(int seed);
        logic [1023:0] b;
        logic [31:0] v;
        v = 32'h6A09E667 ^ 32'(seed);
        for (int k = 0; k < 32; k++) begin
            v = v * 32'h0019660D + 32'h3C6EF35F + 32'(k);
            b[32*k +: 32] = v;
        end
        return b;
    endfunction

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle reference model
    logic         m_busy = 1'b0;
    logic         m_done = 1'b0;
    int           m_cnt = 0;
    logic [255:0] m_state = INIT_VEC;
    logic [255:0] m_pend = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0;
            m_done = 1'b0;
            m_cnt = 0;
            m_state = INIT_VEC;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 160) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_state = m_pend;
                end
            end else if (iv_load) begin
                m_state = INIT_VEC;
            end else if (start) begin
                m_busy = 1'b1;
                m_cnt = 0;
                m_pend = ref_compress(m_state, block_in);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2 busy", 256'(busy), 256'(m_busy));
            check("R3 done", 256'(done), 256'(m_done));
            check(m_done ? "R5 result" : "R6 state", state_out, m_state);
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_block(input logic [1023:0] b);
        @(negedge clk);
        block_in = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic pulse_iv();
        @(negedge clk);
        iv_load = 1'b1;
        @(negedge clk);
        iv_load = 1'b0;
    endtask

    initial begin
        logic [255:0] h1;
        logic [255:0] h2;
        logic [1023:0] ba;
        logic [1023:0] bb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check("R8 busy", 256'(busy), 256'(0));
        check("R8 done", 256'(done), 256'(0));
        check("R8 state", state_out, INIT_VEC);

        // R5 all-zero block from the initial vector
        run_block('0);
        check("R5 zero block", state_out, ref_compress(INIT_VEC, '0));
        @(negedge clk);
        check("R3 done low after pulse", 256'(done), 256'(0));

        // R1 reload in idle
        pulse_iv();
        check("R1 reload", state_out, INIT_VEC);

        // R5 all-ones block
        run_block({1024{1'b1}});
        check("R5 ones block", state_out, ref_compress(INIT_VEC, {1024{1'b1}}));

        // R7 chaining two blocks
        pulse_iv();
        ba = mk_block(11);
        bb = mk_block(23);
        h1 = ref_compress(INIT_VEC, ba);
        h2 = ref_compress(h1, bb);
        run_block(ba);
        check("R7 first", state_out, h1);
        run_block(bb);
        check("R7 chained", state_out, h2);

        // R9 single nonzero word at position 5 (bits 191:160)
        pulse_iv();
        ba = '0;
        ba[32*5 +: 32] = 32'h80000001;
        run_block(ba);
        check("R9 word5", state_out, ref_compress(INIT_VEC, ba));
        h1 = state_out;
        bb = '0;
        bb[32*26 +: 32] = 32'h80000001;
        pulse_iv();
        run_block(bb);
        check("R9 word26", state_out, ref_compress(INIT_VEC, bb));

        // R4 start and new data during a run are ignored; R1 iv_load during run ignored
        pulse_iv();
        ba = mk_block(77);
        bb = mk_block(78);
        @(negedge clk);
        block_in = ba;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        block_in = bb;
        start = 1'b1;
        iv_load = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        iv_load = 1'b0;
        wait_done();
        check("R4 ignored start", state_out, ref_compress(INIT_VEC, ba));
        check("R1 ignored load", 256'(state_out == INIT_VEC), 256'(0));

        // R2 start together with iv_load is not taken
        @(negedge clk);
        block_in = mk_block(5);
        start = 1'b1;
        iv_load = 1'b1;
        @(negedge clk);
        start = 1'b0;
        iv_load = 1'b0;
        check("R2 no start with load", 256'(busy), 256'(0));
        check("R1 load wins", state_out, INIT_VEC);
        @(negedge clk);
        check("R2 still idle", 256'(busy), 256'(0));

        // R2 back-to-back starts on the first idle cycle
        run_block(mk_block(9));
        h1 = state_out;
        run_block(mk_block(10));
        check("R7 back to back", state_out, ref_compress(h1, mk_block(10)));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule